// File: doc/BRIEF.md
# Charger Protection Fault Sequencer

This block sits between the comparators of a single-cell battery charger's power stage and the switches of its power path. It takes seven asynchronous comparator flags: input over-voltage, system over-voltage, battery over-voltage, battery below the short threshold, battery below the discharge floor, system over-current and source insertion. From them it drives four outputs: the converter switching enable, the charge enable, the battery switch enable and a low-current precharge select. It also keeps a sticky fault status word for a host and pulses an interrupt line.

Over-voltage faults stop the stage at once and release it by themselves once the flag clears. A shorted battery gets a timed recovery. The battery switch opens, stays open for a fixed delay derived from the clock frequency, and then closes again with the precharge current selected. A system over-current latches every enable off. Only a fresh source insertion releases that latch. The host reads the status word as a plain port and clears it with a one-cycle strobe.

Top module: `chg_prot_seq`

## Requirements
- R1: Every asynchronous flag input (`vin_ovp_i`, `vsys_ovp_i`, `vbat_ovp_i`, `vbat_short_i`, `vbat_low_i`, `sys_oc_i`, `src_ins_i`) passes two flip-flops before use. A change takes effect on outputs after the second rising clock edge, not the first.
- R2: `sw_en_o` is low in every cycle in which the synchronized input over-voltage or system over-voltage flag is high. It returns high as soon as both are low, unless the over-current latch is set.
- R3: `chg_en_o` is low whenever the synchronized battery over-voltage, input over-voltage or system over-voltage flag is high, or over-current is active. Otherwise it is high.
- R4: `stat_o` bits [1:0] form the input fault code: 01 while an input over-voltage was seen, 00 otherwise. Bit 2 is system over-voltage, bit 3 battery over-voltage, bit 4 battery short and bit 5 system over-current. A bit sets one cycle after its synchronized flag is high and stays set until `rd_clr_i` is sampled high. A bit whose flag is still high stays set through the strobe.
- R5: `irq_o` is high for exactly one cycle, one cycle after each rising edge of any synchronized fault flag (input OVP, system OVP, battery OVP, battery short, over-current).
- R6: In normal operation `bat_sw_en_o` drops in the same cycle the synchronized short flag is first seen high.
- R7: Exactly WAIT = CLK_HZ/1e6 × RETRY_US cycles after that turn-off cycle, `bat_sw_en_o` returns high with `pre_sel_o` high.
- R8: A new rising edge of the synchronized short flag during the wait restarts the full WAIT count. A rising edge during precharge opens the switch again and starts a new wait.
- R9: `pre_sel_o` falls one cycle after the synchronized short flag is seen low during precharge.
- R10: `bat_sw_en_o` is low whenever `supp_req_i` and the synchronized discharge-floor flag are both high.
- R11: A synchronized over-current flag forces `sw_en_o`, `chg_en_o` and `bat_sw_en_o` low and sets a latch. Only a rising edge of the synchronized source-insertion flag, seen while over-current is absent, clears the latch. `rd_clr_i` and elapsed time do not.
- R12: After reset the block is idle: `sw_en_o`, `chg_en_o` and `bat_sw_en_o` high, `pre_sel_o` and `irq_o` low, and `stat_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_ovp_i | input | 1 | Input over-voltage comparator flag (async) |
| vsys_ovp_i | input | 1 | System over-voltage comparator flag (async) |
| vbat_ovp_i | input | 1 | Battery over-voltage comparator flag (async) |
| vbat_short_i | input | 1 | Battery below short threshold (async) |
| vbat_low_i | input | 1 | Battery below discharge floor (async) |
| sys_oc_i | input | 1 | System over-current flag (async) |
| src_ins_i | input | 1 | Source insertion event (async, one or more cycles) |
| supp_req_i | input | 1 | Request to supply the system from the battery (synchronous) |
| rd_clr_i | input | 1 | Host read-clear strobe for the status word |
| sw_en_o | output | 1 | Converter switching enable |
| chg_en_o | output | 1 | Charge enable |
| bat_sw_en_o | output | 1 | Battery switch enable |
| pre_sel_o | output | 1 | Low-current precharge select |
| stat_o | output | 6 | Sticky fault status word |
| irq_o | output | 1 | One-cycle host interrupt pulse |

## Verification
The bench targets the exact length of the short-recovery off window. A counter that is off by one would reclose the battery switch a cycle early or late. It also re-raises the short flag mid-wait and mid-precharge, where a design that fails to restart would reclose the switch too soon. Read-clear strobes arrive while a fault is still present, to catch a status bit that is lost rather than re-set. Over-current is released while strobes and long waits are applied, before any insertion arrives, which exposes a latch that clears too early. An input flag is checked after one edge and after two, which catches a missing synchronizer stage.

// File: rtl/chg_prot_pkg.sv
package chg_prot_pkg;

    localparam int NUM_ASYNC = 7;
    localparam int IDX_VIN   = 0;
    localparam int IDX_VSYS  = 1;
    localparam int IDX_VBAT  = 2;
    localparam int IDX_SHORT = 3;
    localparam int IDX_LOW   = 4;
    localparam int IDX_OC    = 5;
    localparam int IDX_SRC   = 6;

    localparam int NUM_FAULT = 5;
    localparam int STAT_W    = 6;

    typedef enum logic [1:0] {
        SH_NORM  = 2'd0,
        SH_OFF   = 2'd1,
        SH_RETRY = 2'd2
    } sh_state_e;

endpackage

// File: rtl/chg_prot_sync.sv
module chg_prot_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stab;

    AST_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sync_o == $past(st_q.meta)); // R1

endmodule

// File: rtl/chg_prot_short_seq.sv
module chg_prot_short_seq
    import chg_prot_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic short_s,
    output logic kill_o,
    output logic pre_sel_o
);

    localparam int unsigned CW = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CW-1:0] TERM = CW'(WAIT_CYC - 2);

    typedef struct packed {
        sh_state_e     st;
        logic [CW-1:0] cnt;
        logic          prev;
    } short_t;

    short_t st_d, st_q;
    logic   rise;

    assign rise = short_s & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = short_s;
        unique case (st_q.st)
            SH_NORM: begin
                if (short_s) begin
                    st_d.st  = SH_OFF;
                    st_d.cnt = '0;
                end
            end
            SH_OFF: begin
                if (rise) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == TERM) begin
                    st_d.st  = SH_RETRY;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            SH_RETRY: begin
                if (rise) begin
                    st_d.st  = SH_OFF;
                    st_d.cnt = '0;
                end else if (!short_s) begin
                    st_d.st = SH_NORM;
                end
            end
            default: begin
                st_d.st  = SH_NORM;
                st_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: SH_NORM, cnt: '0, prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.st)
            SH_NORM:  kill_o = short_s;
            SH_OFF:   kill_o = 1'b1;
            SH_RETRY: kill_o = rise;
            default:  kill_o = 1'b1;
        endcase
    end

    assign pre_sel_o = (st_q.st == SH_RETRY);

    AST_TRIP_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == SH_NORM && short_s) |=> (st_q.st == SH_OFF && st_q.cnt == '0)); // R6

    AST_RETRY_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == SH_OFF && st_q.cnt == TERM && !rise) |=> st_q.st == SH_RETRY); // R7

    AST_RESTART_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st != SH_NORM && rise) |=> (st_q.st == SH_OFF && st_q.cnt == '0)); // R8

    AST_PRE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == SH_RETRY && !short_s) |=> !pre_sel_o); // R9

endmodule

// File: rtl/chg_prot_status.sv
module chg_prot_status
    import chg_prot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FAULT-1:0] flt_s,
    input  logic                 rd_clr_i,
    output logic [STAT_W-1:0]    stat_o,
    output logic                 irq_o
);

    typedef struct packed {
        logic [NUM_FAULT-1:0] sticky;
        logic [NUM_FAULT-1:0] prev;
        logic                 irq;
    } stat_t;

    stat_t st_d, st_q;
    logic [NUM_FAULT-1:0] rise;

    assign rise = flt_s & ~st_q.prev;

    always_comb begin
        st_d        = st_q;
        st_d.prev   = flt_s;
        st_d.irq    = |rise;
        st_d.sticky = flt_s | (st_q.sticky & ~{NUM_FAULT{rd_clr_i}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // input fault code occupies [1:0] (01 = over-voltage); the rest are single bits
    assign stat_o = {st_q.sticky[4], st_q.sticky[3], st_q.sticky[2],
                     st_q.sticky[1], 1'b0, st_q.sticky[0]};
    assign irq_o  = st_q.irq;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((st_q.sticky & $past(st_q.sticky)) == $past(st_q.sticky))); // R4

    AST_CLEAR_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> (st_q.sticky == $past(flt_s))); // R4

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(flt_s & ~st_q.prev))); // R5

endmodule

// File: rtl/chg_prot_seq.sv
module chg_prot_seq
    import chg_prot_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned RETRY_US = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vin_ovp_i,
    input  logic              vsys_ovp_i,
    input  logic              vbat_ovp_i,
    input  logic              vbat_short_i,
    input  logic              vbat_low_i,
    input  logic              sys_oc_i,
    input  logic              src_ins_i,
    input  logic              supp_req_i,
    input  logic              rd_clr_i,
    output logic              sw_en_o,
    output logic              chg_en_o,
    output logic              bat_sw_en_o,
    output logic              pre_sel_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              irq_o
);

    localparam int unsigned WAIT_CYC = (CLK_HZ / 1_000_000) * RETRY_US;

    logic [NUM_ASYNC-1:0] raw, syn;
    logic vin_s, vsys_s, vbat_s, short_s, low_s, oc_s, src_s;
    logic short_kill;
    logic oc_kill;
    logic src_rise;

    typedef struct packed {
        logic oc_lat;
        logic src_prev;
    } oc_t;

    oc_t st_d, st_q;

    always_comb begin
        raw            = '0;
        raw[IDX_VIN]   = vin_ovp_i;
        raw[IDX_VSYS]  = vsys_ovp_i;
        raw[IDX_VBAT]  = vbat_ovp_i;
        raw[IDX_SHORT] = vbat_short_i;
        raw[IDX_LOW]   = vbat_low_i;
        raw[IDX_OC]    = sys_oc_i;
        raw[IDX_SRC]   = src_ins_i;
    end

    chg_prot_sync #(.W(NUM_ASYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw),
        .sync_o (syn)
    );

    assign vin_s   = syn[IDX_VIN];
    assign vsys_s  = syn[IDX_VSYS];
    assign vbat_s  = syn[IDX_VBAT];
    assign short_s = syn[IDX_SHORT];
    assign low_s   = syn[IDX_LOW];
    assign oc_s    = syn[IDX_OC];
    assign src_s   = syn[IDX_SRC];

    chg_prot_short_seq #(.WAIT_CYC(WAIT_CYC)) u_short (
        .clk      (clk),
        .rst_n    (rst_n),
        .short_s  (short_s),
        .kill_o   (short_kill),
        .pre_sel_o(pre_sel_o)
    );

    chg_prot_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .flt_s   ({oc_s, short_s, vbat_s, vsys_s, vin_s}),
        .rd_clr_i(rd_clr_i),
        .stat_o  (stat_o),
        .irq_o   (irq_o)
    );

    // over-current latch: set by the flag, released only by a new insertion
    assign src_rise = src_s & ~st_q.src_prev;

    always_comb begin
        st_d          = st_q;
        st_d.src_prev = src_s;
        if (oc_s) begin
            st_d.oc_lat = 1'b1;
        end else if (src_rise) begin
            st_d.oc_lat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oc_kill     = st_q.oc_lat | oc_s;
    assign sw_en_o     = ~(vin_s | vsys_s | oc_kill);
    assign chg_en_o    = sw_en_o & ~vbat_s;
    assign bat_sw_en_o = ~(short_kill | oc_kill | (supp_req_i & low_s));

    AST_OVP_STOPS_SW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vin_s) || $rose(vsys_s)) |-> !sw_en_o); // R2

    AST_BATOVP_STOPS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vbat_s) |-> !chg_en_o); // R3

    AST_OC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.oc_lat && !src_rise) |=> (!bat_sw_en_o && !sw_en_o)); // R11

    AST_FLOOR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_s) && supp_req_i |-> !bat_sw_en_o); // R10

    AST_PRE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pre_sel_o) && !oc_kill && !(supp_req_i && low_s) |-> bat_sw_en_o); // R7

endmodule

// File: tb/chg_prot_seq_tb.sv
`timescale 1ns/1ps
module chg_prot_seq_tb;

    localparam int RETRY_US = 2;
    localparam int WAITN    = 50 * RETRY_US;  // 50 cycles per microsecond at 50 MHz

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin = 0, vsys = 0, vbat = 0, vshort = 0, vlow = 0, oc = 0, src = 0;
    logic supp = 0, rdclr = 0;
    logic sw_en, chg_en, bat_en, pre_sel, irq;
    logic [5:0] stat;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #10 clk = ~clk;

    chg_prot_seq #(.CLK_HZ(50_000_000), .RETRY_US(RETRY_US)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .vin_ovp_i(vin), .vsys_ovp_i(vsys), .vbat_ovp_i(vbat),
        .vbat_short_i(vshort), .vbat_low_i(vlow), .sys_oc_i(oc), .src_ins_i(src),
        .supp_req_i(supp), .rd_clr_i(rdclr),
        .sw_en_o(sw_en), .chg_en_o(chg_en), .bat_sw_en_o(bat_en),
        .pre_sel_o(pre_sel), .stat_o(stat), .irq_o(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [6:0] m1, m2, mo;
    logic [4:0] mflt, mfprev, fnow;
    logic       mirq, moc, msrcp, mshp, shr;
    int         mst;     // 0 normal, 1 waiting off, 2 precharge
    int         mcnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1 = 0; m2 = 0; mflt = 0; mfprev = 0; mirq = 0;
            moc = 0; msrcp = 0; mshp = 0; mst = 0; mcnt = 0;
        end else begin
            mo = m2;
            m2 = m1;
            m1 = {src, oc, vlow, vshort, vbat, vsys, vin};
            shr = mo[3] && !mshp;
            if (mst == 0) begin
                if (mo[3]) begin mst = 1; mcnt = 0; end
            end else if (mst == 1) begin
                if (shr) mcnt = 0;
                else if (mcnt == WAITN - 2) begin mst = 2; mcnt = 0; end
                else mcnt = mcnt + 1;
            end else begin
                if (shr) begin mst = 1; mcnt = 0; end
                else if (!mo[3]) mst = 0;
            end
            mshp = mo[3];
            moc = mo[5] || (moc && !(mo[6] && !msrcp));
            msrcp = mo[6];
            fnow = {mo[5], mo[3], mo[2], mo[1], mo[0]};
            mirq = |(fnow & ~mfprev);
            mfprev = fnow;
            mflt = fnow | (rdclr ? 5'b0 : mflt);
        end
    end

    function automatic logic exp_sw();
        return !(m2[0] || m2[1] || moc || m2[5]);
    endfunction
    function automatic logic exp_bat();
        logic kill;
        kill = (mst == 1) || (mst == 0 && m2[3]) || (mst == 2 && m2[3] && !mshp);
        return !(kill || moc || m2[5] || (supp && m2[4]));
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at cycle %0d", req, got, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cmp_on && rst_n) begin
            chk("R2 sw_en", sw_en, exp_sw());
            chk("R3 chg_en", chg_en, exp_sw() && !m2[2]);
            chk("R6 R7 R8 R10 R11 bat_sw_en", bat_en, exp_bat());
            chk("R7 R9 pre_sel", pre_sel, mst == 2);
            chk("R4 stat", stat, {mflt[4], mflt[3], mflt[2], mflt[1], 1'b0, mflt[0]});
            chk("R5 irq", irq, mirq);
        end
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R12: idle outputs after reset
        chk("R12 reset sw", sw_en, 1); chk("R12 reset chg", chg_en, 1);
        chk("R12 reset bat", bat_en, 1); chk("R12 reset pre", pre_sel, 0);
        chk("R12 reset stat", stat, 0); chk("R12 reset irq", irq, 0);
        cmp_on = 1;

        // R1: two synchronizer stages
        vin = 1; tick(1);
        chk("R1 one edge", sw_en, 1);
        tick(1);
        chk("R1 two edges", sw_en, 0);
        tick(1);
        chk("R2 input code 01", stat[1:0], 2'b01);
        tick(5); vin = 0; tick(4);
        chk("R2 resume", sw_en, 1);
        rdclr = 1; tick(1); rdclr = 0; tick(2);

        // system and battery over-voltage, clear while live
        vsys = 1; tick(6); vsys = 0; tick(3);
        vbat = 1; tick(4);
        chk("R3 batovp chg off", chg_en, 0);
        rdclr = 1; tick(1); rdclr = 0; tick(1);
        chk("R4 live bit re-set", stat[3], 1);
        vbat = 0; tick(3);
        rdclr = 1; tick(1); rdclr = 0; tick(2);
        chk("R4 cleared", stat, 0);

        // R6 R7: plain short recovery, flag held
        vshort = 1; tick(2);
        chk("R6 turn-off", bat_en, 0);
        tick(WAITN - 1);
        chk("R7 still off", bat_en, 0);
        tick(1);
        chk("R7 reclosed", bat_en, 1);
        chk("R7 precharge", pre_sel, 1);
        tick(10); vshort = 0; tick(2);
        chk("R9 seen low", pre_sel, 1);
        tick(1);
        chk("R9 precharge released", pre_sel, 0);
        tick(5);

        // R8: restart in wait and trip in precharge
        vshort = 1; tick(30); vshort = 0; tick(5); vshort = 1; tick(2);
        chk("R8 still off after restart", bat_en, 0);
        tick(WAITN - 1);
        chk("R8 full wait again", bat_en, 0);
        tick(1);
        chk("R8 reclosed after restart", bat_en, 1);
        vshort = 0; tick(1); vshort = 1; tick(2);
        chk("R8 trip in precharge", bat_en, 0);
        vshort = 0; tick(WAITN + 10);
        rdclr = 1; tick(1); rdclr = 0; tick(3);

        // R10: discharge floor blocks supplement
        vlow = 1; tick(3); supp = 1; tick(1);
        chk("R10 blocked", bat_en, 0);
        supp = 0; tick(1);
        chk("R10 no supp", bat_en, 1);
        vlow = 0; tick(3);

        // R11: over-current latch
        oc = 1; tick(3);
        chk("R11 all off", {sw_en, chg_en, bat_en}, 3'b000);
        oc = 0; tick(WAITN * 3);
        rdclr = 1; tick(1); rdclr = 0; tick(2);
        chk("R11 held after clear and time", {sw_en, bat_en}, 2'b00);
        src = 1; tick(2); src = 0; tick(2);
        chk("R11 released by insertion", {sw_en, bat_en}, 2'b11);
        oc = 1; src = 1; tick(4); oc = 0; tick(4);
        chk("R11 insertion during oc ignored", bat_en, 0);
        src = 0; tick(3); src = 1; tick(3); src = 0; tick(3);

        // mixed pseudo-random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            vin = (r[3:0] == 0) ? ~vin : vin;
            vsys = (r[7:4] == 0) ? ~vsys : vsys;
            vbat = (r[11:8] == 0) ? ~vbat : vbat;
            vshort = (r[17:12] == 0) ? ~vshort : vshort;
            vlow = (r[20:18] == 0) ? ~vlow : vlow;
            oc = (r[27:21] == 0);
            src = (r[31:28] == 0);
            supp = r[19];
            rdclr = (r[15:13] == 0);
            tick(1);
        end
        {vin, vsys, vbat, vshort, vlow, oc, src, supp, rdclr} = '0;
        tick(WAITN + 20);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule